// File: doc/BRIEF.md
# Bank Mapper with Latched Real-Time Clock

This block sits on a CPU write bus and does two jobs. It supplies a 7-bit ROM bank number and a 2-bit external RAM bank number. It also keeps a time-of-day clock that runs from a 1 Hz tick. The clock has seconds, minutes, hours and a 9-bit day count. The CPU decodes a 3-bit address page (address bits 15:13) and writes a byte. Each page has its own meaning: RAM/clock enable, ROM bank, window select, latch control, and the RAM window itself.

The running counters cannot be read directly. Software first takes a snapshot with a write of 0 and then a write of 1 to the latch page. The snapshot appears as five byte-wide registers. When the window select points at a clock register and the window is enabled, the read port shows the selected snapshot byte. While the clock is shown, writes into the window load the selected running counter. Register 4 holds three things: bit 8 of the day count, a halt flag and a sticky overflow flag.

Top module: `rtc_bank_mapper`

## Requirements
- R1: After reset: rom_bank = 1, ram_bank = 0, window enable off, clock view off, window read = 0xFF, all running counters and all snapshot registers zero.
- R2: A write to page 0 with value 0x0A turns the window enable on. Value 0x00 turns it off. Any other value leaves it unchanged.
- R3: A write to page 1 sets rom_bank to value bits [6:0], except that a result of 0 is stored as 1.
- R4: On page 2, a value of 0–3 sets ram_bank to that value and turns the clock view off. A value of 0x08–0x0C selects clock register (value − 8) and turns the clock view on. Every other value changes nothing.
- R5: On page 3, a write of 0x01 while the latch state is clear copies all running counters into the snapshot registers and sets the latch state. A write of 0x00 while the latch state is set clears it. All other writes change neither the latch state nor the snapshot.
- R6: Each tick adds one second when the halt flag is clear. Seconds and minutes wrap from 59 to 0, hours wrap from 23 to 0, and each wrap carries into the next field.
- R7: The day count is 9 bits wide. Register 3 reads bits [7:0], and bit 0 of register 4 reads bit 8. A carry from hours increments the full 9-bit count.
- R8: When the day count wraps from 511 to 0, bit 7 of register 4 is set. It stays set through further ticks until software writes register 4 with bit 7 clear.
- R9: While bit 6 of register 4 (halt) is set, ticks do not change any counter.
- R10: A write to page 5 loads the selected running counter, but only when the window enable is on and the clock view is on. Otherwise the write has no effect. Register indices are 0 seconds, 1 minutes, 2 hours, 3 day low, 4 control (bit 0 day[8], bit 6 halt, bit 7 overflow).
- R11: When the window enable and the clock view are both on, the window read shows the snapshot of the selected register, with unused bits as 0. Otherwise it reads 0xFF.
- R12: If a counter-load write and a tick fall in the same cycle, the write wins and that tick is lost. If a capturing latch write and a tick fall in the same cycle, the snapshot holds the values from before the tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_wr | input | 1 | Write strobe |
| bus_page | input | 3 | Address bits 15:13 of the write |
| bus_wdata | input | 8 | Write data byte |
| rom_bank | output | 7 | Selected ROM bank, never 0 |
| ram_bank | output | 2 | Selected external RAM bank |
| ram_enable | output | 1 | Window enable |
| clock_view | output | 1 | Window shows clock registers |
| win_rdata | output | 8 | Window read data |

## Verification
Three events can land in the same clock cycle: a tick, a CPU load of a counter, and a capturing latch write. The bench raises the tick strobe in the same cycle as a load write to the seconds register. It then takes a snapshot and checks that the loaded value appears with no extra second added. It also raises the tick in the same cycle as the capturing latch write. The first snapshot must show the value from before the tick. A second capture must show that tick counted once.

// File: rtl/rtc_mapper_pkg.sv
package rtc_mapper_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int DAY_W = 9;

  localparam logic [2:0] PG_ENABLE = 3'd0;
  localparam logic [2:0] PG_ROM    = 3'd1;
  localparam logic [2:0] PG_SELECT = 3'd2;
  localparam logic [2:0] PG_LATCH  = 3'd3;
  localparam logic [2:0] PG_WINDOW = 3'd5;

  localparam logic [2:0] IDX_SEC  = 3'd0;
  localparam logic [2:0] IDX_MIN  = 3'd1;
  localparam logic [2:0] IDX_HR   = 3'd2;
  localparam logic [2:0] IDX_DAYL = 3'd3;
  localparam logic [2:0] IDX_CTL  = 3'd4;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [MIN_W-1:0] min;
    logic [HR_W-1:0]  hr;
    logic [DAY_W-1:0] day;
    logic             halt;
    logic             ovf;
  } rtc_time_t;
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
  import rtc_mapper_pkg::*;
#(
  parameter int ROM_W      = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            page,
  input  logic [7:0]            wdata,
  output logic [ROM_W-1:0]      rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en,
  output logic                  rtc_on,
  output logic [2:0]            rtc_idx,
  output logic                  latch_fire,
  output logic                  cnt_load
);
  localparam logic [7:0] RAM_BANKS = 8'(2 ** RAM_BANK_W);

  logic [ROM_W-1:0]      rom_q, rom_d, rom_val;
  logic [RAM_BANK_W-1:0] bank_q, bank_d;
  logic                  en_q, en_d, view_q, view_d, latch_q, latch_d;
  logic [2:0]            idx_q, idx_d;

  assign rom_val = wdata[ROM_W-1:0];

  always_comb begin
    rom_d      = rom_q;
    bank_d     = bank_q;
    en_d       = en_q;
    view_d     = view_q;
    idx_d      = idx_q;
    latch_d    = latch_q;
    latch_fire = 1'b0;
    cnt_load   = 1'b0;
    if (wr_en) begin
      case (page)
        PG_ENABLE: begin
          if (wdata == 8'h0A)      en_d = 1'b1;
          else if (wdata == 8'h00) en_d = 1'b0;
        end
        PG_ROM: rom_d = (rom_val == '0) ? ROM_W'(1) : rom_val;
        PG_SELECT: begin
          if (wdata < RAM_BANKS) begin
            bank_d = wdata[RAM_BANK_W-1:0];
            view_d = 1'b0;
          end else if (wdata >= 8'h08 && wdata <= 8'h0C) begin
            idx_d  = wdata[2:0];  // equals value minus 8 in this range
            view_d = 1'b1;
          end
        end
        PG_LATCH: begin
          if (latch_q && wdata == 8'h00) begin
            latch_d = 1'b0;
          end else if (!latch_q && wdata == 8'h01) begin
            latch_d    = 1'b1;
            latch_fire = 1'b1;
          end
        end
        PG_WINDOW: cnt_load = en_q && view_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_q   <= ROM_W'(1);
      bank_q  <= '0;
      en_q    <= 1'b0;
      view_q  <= 1'b0;
      idx_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      rom_q   <= rom_d;
      bank_q  <= bank_d;
      en_q    <= en_d;
      view_q  <= view_d;
      idx_q   <= idx_d;
      latch_q <= latch_d;
    end
  end

  assign rom_bank = rom_q;
  assign ram_bank = bank_q;
  assign ram_en   = en_q;
  assign rtc_on   = view_q;
  assign rtc_idx  = idx_q;
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_mapper_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  logic [2:0] load_idx,
  input  logic [7:0] load_data,
  output rtc_time_t live
);
  rtc_time_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    if (load) begin
      case (load_idx)
        IDX_SEC:  nxt.sec = load_data[SEC_W-1:0];
        IDX_MIN:  nxt.min = load_data[MIN_W-1:0];
        IDX_HR:   nxt.hr  = load_data[HR_W-1:0];
        IDX_DAYL: nxt.day[7:0] = load_data;
        IDX_CTL: begin
          nxt.day[8] = load_data[0];
          nxt.halt   = load_data[6];
          nxt.ovf    = load_data[7];
        end
        default: ;
      endcase
    end else if (tick && !cur_q.halt) begin
      if (cur_q.sec != SEC_W'(59)) begin
        nxt.sec = cur_q.sec + 1'b1;
      end else begin
        nxt.sec = '0;
        if (cur_q.min != MIN_W'(59)) begin
          nxt.min = cur_q.min + 1'b1;
        end else begin
          nxt.min = '0;
          if (cur_q.hr != HR_W'(23)) begin
            nxt.hr = cur_q.hr + 1'b1;
          end else begin
            nxt.hr  = '0;
            nxt.day = cur_q.day + 1'b1;
            if (cur_q.day == '1) nxt.ovf = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign live = cur_q;
endmodule

// File: rtl/rtc_latch_bank.sv
module rtc_latch_bank
  import rtc_mapper_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  rtc_time_t  live,
  input  logic [2:0] idx,
  input  logic       show,
  output logic [7:0] rd_data
);
  rtc_time_t snap_q, snap_d;

  always_comb begin
    snap_d = capture ? live : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  always_comb begin
    rd_data = 8'hFF;
    if (show) begin
      case (idx)
        IDX_SEC:  rd_data = 8'(snap_q.sec);
        IDX_MIN:  rd_data = 8'(snap_q.min);
        IDX_HR:   rd_data = 8'(snap_q.hr);
        IDX_DAYL: rd_data = snap_q.day[7:0];
        IDX_CTL:  rd_data = {snap_q.ovf, snap_q.halt, 5'b0, snap_q.day[8]};
        default:  rd_data = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/rtc_bank_mapper.sv
module rtc_bank_mapper
  import rtc_mapper_pkg::*;
#(
  parameter int ROM_W      = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_1hz,
  input  logic                  bus_wr,
  input  logic [2:0]            bus_page,
  input  logic [7:0]            bus_wdata,
  output logic [ROM_W-1:0]      rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_enable,
  output logic                  clock_view,
  output logic [7:0]            win_rdata
);
  logic      rst_meta, rst_sync;
  logic      latch_fire, cnt_load;
  logic [2:0] rtc_idx;
  rtc_time_t live_time;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  rtc_bus_decode #(.ROM_W(ROM_W), .RAM_BANK_W(RAM_BANK_W)) u_decode (
    .clk(clk), .rst_n(rst_sync), .wr_en(bus_wr), .page(bus_page),
    .wdata(bus_wdata), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .ram_en(ram_enable), .rtc_on(clock_view), .rtc_idx(rtc_idx),
    .latch_fire(latch_fire), .cnt_load(cnt_load)
  );

  rtc_time_counter u_count (
    .clk(clk), .rst_n(rst_sync), .tick(tick_1hz), .load(cnt_load),
    .load_idx(rtc_idx), .load_data(bus_wdata), .live(live_time)
  );

  rtc_latch_bank u_snap (
    .clk(clk), .rst_n(rst_sync), .capture(latch_fire), .live(live_time),
    .idx(rtc_idx), .show(ram_enable && clock_view), .rd_data(win_rdata)
  );
endmodule

// File: rtl/rtc_mapper_chk.sv
module rtc_mapper_chk
  import rtc_mapper_pkg::*;
#(
  parameter int ROM_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [ROM_W-1:0] rom_bank,
  input logic             win_open,
  input logic [7:0]       rd_data,
  input logic             cnt_load,
  input logic [2:0]       idx,
  input logic [7:0]       wdata,
  input rtc_time_t        live
);
  assert_rom_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rom_bank != '0);

  assert_window_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> rd_data == 8'hFF);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    live.ovf && !(cnt_load && idx == IDX_CTL) |=> live.ovf);

  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    live.halt && !cnt_load |=> $stable(live));

  assert_sec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live.sec <= SEC_W'(59) && !cnt_load |=> live.sec <= SEC_W'(59));

  assert_load_beats_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load && tick && idx == IDX_SEC |=> live.sec == $past(wdata[SEC_W-1:0]));
endmodule

bind rtc_bank_mapper rtc_mapper_chk #(.ROM_W(ROM_W)) u_chk (
  .clk(clk), .rst_n(rst_sync), .tick(tick_1hz), .rom_bank(rom_bank),
  .win_open(ram_enable && clock_view), .rd_data(win_rdata),
  .cnt_load(cnt_load), .idx(rtc_idx), .wdata(bus_wdata), .live(live_time)
);

// File: tb/rtc_bank_mapper_tb.sv
`timescale 1ns/1ps
module rtc_bank_mapper_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1hz;
  logic       bus_wr;
  logic [2:0] bus_page;
  logic [7:0] bus_wdata;
  logic [6:0] rom_bank;
  logic [1:0] ram_bank;
  logic       ram_enable, clock_view;
  logic [7:0] win_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_wr(bus_wr),
    .bus_page(bus_page), .bus_wdata(bus_wdata), .rom_bank(rom_bank),
    .ram_bank(ram_bank), .ram_enable(ram_enable), .clock_view(clock_view),
    .win_rdata(win_rdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] pg, input logic [7:0] d);
    bus_wr = 1'b1; bus_page = pg; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
    end
  endtask

  task automatic do_latch();
    wr(3'd3, 8'h00);
    wr(3'd3, 8'h01);
  endtask

  task automatic set_reg(input int idx, input logic [7:0] v);
    wr(3'd2, 8'(8 + idx));
    wr(3'd5, v);
  endtask

  task automatic rd_reg(input int idx, output int v);
    wr(3'd2, 8'(8 + idx));
    v = int'(win_rdata);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, t, exp_bank, exp_rd;
    int snap_tab[5];
    rst_n = 1'b0; tick_1hz = 1'b0; bus_wr = 1'b0; bus_page = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rom_bank", int'(rom_bank), 1);
    chk("R1 ram_bank", int'(ram_bank), 0);
    chk("R1 ram_enable", int'(ram_enable), 0);
    chk("R1 clock_view", int'(clock_view), 0);
    chk("R1 win_rdata", int'(win_rdata), 8'hFF);

    // R2 enable handling
    wr(3'd0, 8'h0A); chk("R2 enable", int'(ram_enable), 1);
    wr(3'd0, 8'h05); chk("R2 other value keeps on", int'(ram_enable), 1);
    wr(3'd0, 8'h00); chk("R2 disable", int'(ram_enable), 0);
    wr(3'd0, 8'hFF); chk("R2 other value keeps off", int'(ram_enable), 0);
    wr(3'd0, 8'h0A);

    // R1 snapshot registers start at zero
    for (int i = 0; i < 5; i++) begin
      rd_reg(i, v); chk("R1 snapshot zero", v, 0);
    end

    // R3 exhaustive ROM bank sweep
    for (int d = 0; d < 256; d++) begin
      wr(3'd1, 8'(d));
      chk("R3 rom bank", int'(rom_bank), ((d & 8'h7F) == 0) ? 1 : (d & 8'h7F));
    end

    // R6 counting sweep against arithmetic model
    t = 0;
    for (int k = 0; k < 40; k++) begin
      ticks(97); t += 97;
      do_latch();
      rd_reg(0, v); chk("R6 seconds", v, t % 60);
      rd_reg(1, v); chk("R6 minutes", v, (t / 60) % 60);
      rd_reg(2, v); chk("R6 hours", v, (t / 3600) % 24);
      rd_reg(3, v); chk("R7 day low", v, 0);
    end

    // R7 day carry into bit 8 (register 4 bit 0)
    set_reg(0, 59); set_reg(1, 59); set_reg(2, 23); set_reg(3, 8'hFF); set_reg(4, 8'h00);
    ticks(1); do_latch();
    rd_reg(0, v); chk("R6 sec wrap", v, 0);
    rd_reg(2, v); chk("R6 hour wrap", v, 0);
    rd_reg(3, v); chk("R7 day low after 255", v, 0);
    rd_reg(4, v); chk("R7 day bit8", v, 8'h01);

    // R8 overflow flag set and sticky
    set_reg(3, 8'hFF); set_reg(4, 8'h01);
    set_reg(0, 59); set_reg(1, 59); set_reg(2, 23);
    ticks(1); do_latch();
    rd_reg(3, v); chk("R8 day wraps to 0 low", v, 0);
    rd_reg(4, v); chk("R8 overflow set", v, 8'h80);
    ticks(5); do_latch();
    rd_reg(4, v); chk("R8 overflow sticky", v, 8'h80);
    rd_reg(0, v); chk("R6 seconds after wrap", v, 5);
    set_reg(4, 8'h00); do_latch();
    rd_reg(4, v); chk("R8 overflow cleared by write", v, 0);

    // R9 halt
    set_reg(0, 10); set_reg(4, 8'h40);
    ticks(20); do_latch();
    rd_reg(0, v); chk("R9 halted seconds", v, 10);
    rd_reg(4, v); chk("R9 halt flag reads", v, 8'h40);
    set_reg(4, 8'h00); ticks(3); do_latch();
    rd_reg(0, v); chk("R9 resumed seconds", v, 13);

    // R5 latch handshake
    ticks(5);
    wr(3'd3, 8'h01);
    rd_reg(0, v); chk("R5 repeat 1 no capture", v, 13);
    wr(3'd3, 8'h02); wr(3'd3, 8'h01);
    rd_reg(0, v); chk("R5 value 2 does not clear", v, 13);
    wr(3'd3, 8'h00); wr(3'd3, 8'h01);
    rd_reg(0, v); chk("R5 0 then 1 captures", v, 18);

    // R10 / R11 window writes ignored when closed
    wr(3'd2, 8'h08);
    wr(3'd0, 8'h00);
    chk("R11 disabled window reads FF", int'(win_rdata), 8'hFF);
    wr(3'd5, 8'd40);
    wr(3'd0, 8'h0A);
    do_latch();
    rd_reg(0, v); chk("R10 write while disabled ignored", v, 18);
    wr(3'd2, 8'h00);
    chk("R11 view off reads FF", int'(win_rdata), 8'hFF);
    wr(3'd5, 8'd45);
    do_latch();
    rd_reg(0, v); chk("R10 write while view off ignored", v, 18);
    set_reg(4, 8'hFF); do_latch();
    rd_reg(4, v); chk("R11 unused bits zero", v, 8'hC1);
    set_reg(4, 8'h00);

    // R12 load and tick in the same cycle
    wr(3'd2, 8'h08);
    bus_wr = 1'b1; bus_page = 3'd5; bus_wdata = 8'd30; tick_1hz = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_1hz = 1'b0;
    do_latch();
    rd_reg(0, v); chk("R12 load wins over tick", v, 30);
    wr(3'd3, 8'h00);
    bus_wr = 1'b1; bus_page = 3'd3; bus_wdata = 8'h01; tick_1hz = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_1hz = 1'b0;
    rd_reg(0, v); chk("R12 capture sees pre-tick value", v, 30);
    do_latch();
    rd_reg(0, v); chk("R12 tick counted after capture", v, 31);

    // R4 exhaustive select sweep with a known snapshot
    snap_tab = '{17, 34, 5, 8'h77, 8'h41};
    set_reg(4, 8'h41); set_reg(0, 17); set_reg(1, 34); set_reg(2, 5); set_reg(3, 8'h77);
    do_latch();
    for (int d = 0; d < 256; d++) begin
      wr(3'd2, 8'h01);
      wr(3'd2, 8'h0B);
      wr(3'd2, 8'(d));
      exp_bank = (d < 4) ? d : 1;
      if (d < 4)                 exp_rd = 8'hFF;
      else if (d >= 8 && d <= 12) exp_rd = snap_tab[d - 8];
      else                       exp_rd = snap_tab[3];
      chk("R4 ram bank", int'(ram_bank), exp_bank);
      chk("R4 clock view", int'(clock_view), (d >= 4) ? 1 : 0);
      chk("R4 R11 window data", int'(win_rdata), exp_rd);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule